// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Unit

A peripheral with two down-counting timer channels on a small register bus. Each channel counts at the peripheral clock divided by a power of four. When a count step arrives while the counter is zero, the channel reloads its counter from a constant register, sets a sticky underflow flag and, if enabled, drives a level interrupt.

The usual setup gives the two channels different jobs. One channel produces periodic or one-shot events for an event scheduler. The other is loaded with all ones and left running as a wrap-around timebase, whose inverted count rises steadily. One shared start register runs or halts both channels with a single write.

The register map uses byte addresses.
- The start register is at 0x00.
- Channel c uses base address 0x10 + 0x10*c. The control register is at base+0x0, the constant register at base+0x4 and the counter at base+0x8.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset the start register, every counter and every constant register read 0. Each control register reads 0x0020 (interrupt enable set, divide by 4), and both interrupt outputs are low.
- R2: Bit c of the start register (c = 0 or 1) runs channel c. A write loads both bits at once. On read, bits 1:0 return the stored bits and all higher bits return 0.
- R3: A running channel whose counter is nonzero decrements by one on each prescaled step. With select value s, the step period is 4<<(2*s) clocks. After the start bit is written, the first step falls on that many-th rising edge.
- R4: A step that arrives while the counter is zero is an underflow when the constant is nonzero. On an underflow the counter takes the constant value and control bit 8, the underflow flag, becomes 1. The channel then repeats with that period.
- R5: Writing the counter arms the channel for one underflow. With the constant at zero, the armed underflow reloads zero and sets the flag once. After that the counter stays at zero and the flag does not set again.
- R6: Only an underflow sets the flag. A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag as it is. If an underflow and a clearing write fall in the same cycle, the flag stays set.
- R7: Each interrupt output is high exactly when that channel's flag and its control bit 5 (interrupt enable) are both 1.
- R8: The counter and constant registers can be written at any time, including while the channel runs. When a counter write and a step fall in the same cycle, the written value wins.
- R9: With all ones in both registers, a channel wraps from 0 to 0xFFFFFFFF. The inverted counter value then increases over time.
- R10: A read returns its data on rdata one cycle after rd_en is asserted, and rdata holds its value while no read is issued. Addresses outside the map read 0, and writes to them change nothing.
- R11: While a channel's start bit is 0, its counter holds its value and its prescale phase returns to zero.
- R12: Control bits 2:0 select the division. Values 0, 1, 2 and 3 give /4, /16, /64 and /256. Values 4 to 7 behave as /256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data follows one cycle later |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 2 | Level interrupt per channel |

## Verification
A fault in a channel's counter, prescale phase or armed bit shows up first as an interrupt edge in the wrong cycle. The bench therefore compares the interrupt lines with a behavioural model on every clock, so a fault inside one step period, at most 256 clocks, is caught at the next underflow. Faults in the flag or in a stored register show up on the read port one cycle after the read that exposes them. The bench also times the first steps after a start to the exact edge for the /4 and /256 divisions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W     = 16;
  localparam int SEL_W     = 3;
  localparam int SEL_TOP   = 3;       // largest distinct select value
  localparam int FLAG_BIT  = 8;
  localparam int IE_BIT    = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = 16'h0020;
  localparam int START_OFF = 'h00;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int OFF_CTL   = 'h0;
  localparam int OFF_CON   = 'h4;
  localparam int OFF_CNT   = 'h8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = 2 * SEL_TOP + 2;

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] mask;
  logic [SEL_W-1:0] esel;

  always_comb begin
    esel = (sel > SEL_W'(SEL_TOP)) ? SEL_W'(SEL_TOP) : sel;
    mask = (PRE_W'(4) << {esel, 1'b0}) - PRE_W'(1);
    tick = run && ((phase & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= phase + PRE_W'(1);
  end

  // R11: a halted channel restarts its phase from zero
  a_r11_phase_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0 && !tick));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_ctl,
  input  logic             wr_con,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [SEL_W-1:0] sel,
  output logic [CTL_W-1:0] ctl_view,
  output logic [CNT_W-1:0] con_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq
);
  logic flag, ie, armed, uflow, flag_n, ie_n;

  always_comb begin
    uflow  = tick && !wr_cnt && (cnt_q == '0) && ((con_q != '0) || armed);
    flag_n = uflow ? 1'b1 : ((wr_ctl && !wdata[FLAG_BIT]) ? 1'b0 : flag);
    ie_n   = wr_ctl ? wdata[IE_BIT] : ie;
    ctl_view           = '0;
    ctl_view[SEL_W-1:0] = sel;
    ctl_view[IE_BIT]   = ie;
    ctl_view[FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      con_q <= '0;
      sel   <= CTL_RESET[SEL_W-1:0];
      ie    <= CTL_RESET[IE_BIT];
      flag  <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wr_cnt) begin
        cnt_q <= wdata;
        armed <= 1'b1;
      end else if (uflow) begin
        cnt_q <= con_q;
        armed <= 1'b0;
      end else if (tick && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (wr_con) con_q <= wdata;
      if (wr_ctl) sel <= wdata[SEL_W-1:0];
      flag <= flag_n;
      ie   <= ie_n;
      irq  <= flag_n && ie_n;
    end
  end

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    uflow |=> (flag && !$past(wr_con) -> cnt_q == $past(con_q)));
  a_r6_flag_hw_only: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(uflow));
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(cnt_q));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NCH-1:0]    irq
);
  function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int off);
    return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
  endfunction

  logic [NCH-1:0]   run_q;
  logic [CTL_W-1:0] ctl_v [NCH];
  logic [CNT_W-1:0] con_v [NCH];
  logic [CNT_W-1:0] cnt_v [NCH];
  logic [CNT_W-1:0] rd_mux;
  logic             hit_start;

  assign hit_start = (addr == ADDR_W'(START_OFF));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SEL_W-1:0] sel_c;
    logic             tick_c;

    tmr_prescaler u_pre (
      .clk(clk), .rst(rst), .run(run_q[c]), .sel(sel_c), .tick(tick_c)
    );

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick_c),
      .wr_ctl(wr_en && addr == reg_addr(c, OFF_CTL)),
      .wr_con(wr_en && addr == reg_addr(c, OFF_CON)),
      .wr_cnt(wr_en && addr == reg_addr(c, OFF_CNT)),
      .wdata(wdata), .sel(sel_c), .ctl_view(ctl_v[c]),
      .con_q(con_v[c]), .cnt_q(cnt_v[c]), .irq(irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit_start) rd_mux = CNT_W'(run_q);
    for (int c = 0; c < NCH; c++) begin
      if (addr == reg_addr(c, OFF_CTL)) rd_mux = CNT_W'(ctl_v[c]);
      if (addr == reg_addr(c, OFF_CON)) rd_mux = con_v[c];
      if (addr == reg_addr(c, OFF_CNT)) rd_mux = cnt_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && hit_start) run_q <= wdata[NCH-1:0];
      if (rd_en) rdata <= rd_mux;
    end
  end

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_start) |=> (run_q == $past(wdata[NCH-1:0])));
endmodule

// File: tb/tb_tick_timer_unit.sv
module tb_tick_timer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt [2], m_con [2];
  logic [2:0]  m_sel [2];
  bit          m_ie [2], m_flag [2], m_arm [2];
  int          m_pre [2];
  logic [1:0]  m_run;
  logic [31:0] m_rdata;

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] v = 0;
    if (a == 8'h00) v = {30'd0, m_run};
    for (int c = 0; c < 2; c++) begin
      if (a == 8'h10 + 8'(16*c)) v = {23'd0, m_flag[c], 2'd0, m_ie[c], 2'd0, m_sel[c]};
      if (a == 8'h14 + 8'(16*c)) v = m_con[c];
      if (a == 8'h18 + 8'(16*c)) v = m_cnt[c];
    end
    return v;
  endfunction

  int  dv;
  bit  tk, uf, wcnt, wcon, wctl;
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_con[c] = 0; m_sel[c] = 0; m_ie[c] = 1;
        m_flag[c] = 0; m_arm[c] = 0; m_pre[c] = 0;
      end
      m_run = 0; m_rdata = 0;
    end else begin
      if (rd_en) m_rdata = mread(addr);
      for (int c = 0; c < 2; c++) begin
        dv   = 4 << (2 * ((m_sel[c] > 3) ? 3 : int'(m_sel[c])));
        tk   = m_run[c] && ((m_pre[c] % dv) == dv - 1);
        wctl = wr_en && addr == 8'h10 + 8'(16*c);
        wcon = wr_en && addr == 8'h14 + 8'(16*c);
        wcnt = wr_en && addr == 8'h18 + 8'(16*c);
        uf   = tk && !wcnt && m_cnt[c] == 0 && (m_con[c] != 0 || m_arm[c]);
        m_pre[c] = m_run[c] ? (m_pre[c] + 1) % 256 : 0;
        if (wcnt) begin m_cnt[c] = wdata; m_arm[c] = 1; end
        else if (uf) begin m_cnt[c] = m_con[c]; m_arm[c] = 0; end
        else if (tk && m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
        if (wcon) m_con[c] = wdata;
        if (wctl) begin
          m_sel[c] = wdata[2:0]; m_ie[c] = wdata[5];
          if (!wdata[8]) m_flag[c] = 0;
        end
        if (uf) m_flag[c] = 1;
      end
      if (wr_en && addr == 8'h00) m_run = wdata[1:0];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    check(irq == {m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}, "R7 irq vs model",
          32'(irq), 32'({m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}));
    check(rdata == m_rdata, "R10 rdata vs model", rdata, m_rdata);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; v = rdata;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == e, tag, v, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", 32'(irq), 0);
    rd_exp(8'h00, 32'h0, "R1 start reset");
    rd_exp(8'h10, 32'h20, "R1 ctl0 reset");
    rd_exp(8'h14, 32'h0, "R1 con0 reset");
    rd_exp(8'h18, 32'h0, "R1 cnt0 reset");
    rd_exp(8'h20, 32'h20, "R1 ctl1 reset");
    // R2 start register bits
    wr(8'h00, 32'hFF);
    rd_exp(8'h00, 32'h3, "R2 start readback");
    wr(8'h00, 32'h0);
    // R10 unmapped address
    wr(8'h44, 32'h1234);
    rd_exp(8'h44, 32'h0, "R10 unmapped read");
    // R3/R4 periodic on channel 0 at /4
    wr(8'h14, 32'd3);
    wr(8'h18, 32'd3);
    wr(8'h00, 32'h1);                  // edge E0
    repeat (15) @(negedge clk);        // after E15
    check(irq[0] == 1'b0, "R3 no underflow before 16 clocks", 32'(irq[0]), 0);
    @(negedge clk);                    // after E16
    check(irq[0] == 1'b1, "R4 underflow at 16th clock", 32'(irq[0]), 1);
    rd_exp(8'h18, 32'd3, "R4 reload value");       // E17
    rd_exp(8'h10, 32'h120, "R4 flag set");          // E18
    wr(8'h10, 32'h20);                              // E19
    check(irq[0] == 1'b0, "R6 flag cleared by zero", 32'(irq[0]), 0);
    wr(8'h10, 32'h120);                             // E20
    rd_exp(8'h10, 32'h20, "R6 writing one does not set");  // E21
    wr(8'h00, 32'h0);                               // E22, counter 2
    repeat (10) @(negedge clk);
    rd_exp(8'h18, 32'd2, "R11 counter held while stopped");
    // R8 writes while running
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h18, 32'h1000);
    rd_exp(8'h18, 32'h1000, "R8 counter write while running");
    wr(8'h14, 32'h55);
    rd_exp(8'h14, 32'h55, "R8 constant write while running");
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);
    // R7 enable off on channel 1, /16
    wr(8'h20, 32'h1);
    wr(8'h24, 32'd1);
    wr(8'h28, 32'd0);
    wr(8'h00, 32'h2);
    repeat (40) @(negedge clk);
    check(irq[1] == 1'b0, "R7 irq masked", 32'(irq[1]), 0);
    rd_exp(8'h20, 32'h101, "R7 flag set while masked");
    wr(8'h20, 32'h121);
    check(irq[1] == 1'b1, "R7 irq after enable", 32'(irq[1]), 1);
    // R5 one-shot
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd2);
    wr(8'h20, 32'h21);
    repeat (100) @(negedge clk);
    rd_exp(8'h20, 32'h121, "R5 single underflow");
    wr(8'h20, 32'h21);
    repeat (100) @(negedge clk);
    rd_exp(8'h20, 32'h21, "R5 no further event");
    rd_exp(8'h28, 32'd0, "R5 counter stays zero");
    // R9 free-running timebase on channel 0
    wr(8'h10, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'h3);
    repeat (20) @(negedge clk);
    rd(8'h18, v1);
    repeat (30) @(negedge clk);
    rd(8'h18, v2);
    check(~v2 > ~v1, "R9 inverted count increases", ~v2, ~v1);
    wr(8'h18, 32'd1);
    repeat (30) @(negedge clk);
    rd(8'h18, v1);
    check(v1 >= 32'hFFFF_FFF0, "R9 wrap to all ones", v1, 32'hFFFF_FFF0);
    // R12 select 7 behaves as /256, R3 first step timing
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h7);
    wr(8'h18, 32'd10);
    wr(8'h00, 32'h1);                  // E0
    repeat (255) @(negedge clk);       // after E255
    rd_exp(8'h18, 32'd10, "R12 no step before 256 clocks");
    rd_exp(8'h18, 32'd9, "R12 step on 256th clock");
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule